// File: doc/BRIEF.md
# Charge-Path Protection Sequencer

This block drives the charge-enable line of a two-cell battery protector. It does no analog work: comparators elsewhere turn the cell and charger voltages into flags, and this block times and combines them. A cell that stays over its limit opens the charge switch. A charger whose voltage drives the negative terminal too far below ground opens it too. Each fault has a release rule and a release delay of its own. While a cell overcharge is held, the block also tells the discharge side to hold off its overcurrent detection.

Every delay is counted in pulses of a slow enable strobe, nominally 1 kHz, and is set by a parameter. A test input divides every count by 64, with a floor of one pulse, so that production test can run the whole sequence quickly. The two qualifiers are interlocked. Charger-overvoltage detection waits while the discharge switch is off and while an overcharge is held. When an overcharge release completes and an overvoltage charger is still attached, charging stays off because the overvoltage qualifier takes over directly.

Top module: `chg_guard_seq`

## Requirements
- R1: When either bit of `cell_over` stays high for the overcharge detection count of `tick` pulses, `chg_en` goes low and `oc_active` goes high. If both bits drop before the count completes, the timing is abandoned, and the next detection restarts from zero.
- R2: While overcharge is held, the release condition is: both bits of `cell_over` low when `load_on` is 1, or both bits of `cell_low` high when `load_on` is 0. The condition must hold for the release count before `chg_en` returns high. If the condition is lost during that count, the count restarts.
- R3: `ocur_block` and `oc_active` are high for the whole time overcharge is held, including its release count. `chg_en` is low whenever they are high.
- R4: When `chg_ovv` stays high for the overvoltage detection count, `chg_en` goes low while `oc_active` stays low. If `chg_ovv` drops before the count completes, the timing is abandoned.
- R5: After an overvoltage detection, `chg_en` returns high once `chg_ovv` has stayed low for the overvoltage release count. If `chg_ovv` returns during that count, the hold continues.
- R6: While `dis_on` is 0, no overvoltage detection starts and any pending detection count is abandoned. The detection count starts only after `dis_on` returns to 1.
- R7: Overvoltage detection is not armed while overcharge is held. If `chg_ovv` and `dis_on` are both high in the cycle an overcharge release completes, the overvoltage hold begins at once and `chg_en` stays low without a high cycle.
- R8: With `test_fast` at 1, each delay count becomes the normal count shifted right by 6 bits, or 1 if that result is 0.
- R9: A synchronous active-high `rst` clears every timer and state. After reset, `chg_en` is 1 and `oc_active` and `ocur_block` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timing strobe (nominally 1 kHz) |
| test_fast | input | 1 | Shortens all delay counts |
| cell_over | input | 2 | Per-cell flag: voltage at or above the overcharge threshold |
| cell_low | input | 2 | Per-cell flag: voltage at or below the overcharge reset level |
| load_on | input | 1 | A load is connected (0 means a charger is connected) |
| chg_ovv | input | 1 | Charger pulls the negative terminal below the overvoltage level |
| dis_on | input | 1 | Discharge switch is on (discharge output high) |
| chg_en | output | 1 | Charge-switch enable, high means charging allowed |
| oc_active | output | 1 | Cell overcharge is held |
| ocur_block | output | 1 | Blocks overcurrent detection on the discharge side |

## Verification
A qualifier stuck in its timing state shows up as `chg_en` flipping one strobe early or late. For that reason every delay is probed one pulse before its expiry and again at expiry, each check a few clock cycles after the strobe. A wrong release condition shows up as `chg_en` rising while a cell is still over its limit, or never rising, within one release count. A handoff fault shows up as `chg_en` going high in the single cycle between the overcharge release and the overvoltage hold. The bench checks for that case and a bound assertion watches for it.

// File: rtl/chg_guard_pkg.sv
package chg_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_HELD = 2'd2,
        ST_FREE = 2'd3
    } qual_st_e;

    typedef struct packed {
        logic hold;
        logic release_done;
    } qual_out_t;

    localparam int unsigned FAST_SHIFT = 6;

    function automatic int unsigned fast_count(input int unsigned n);
        int unsigned s;
        s = n >> FAST_SHIFT;
        return (s == 0) ? 1 : s;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick && !done)
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt >= limit);
endmodule

// File: rtl/chg_oc_fsm.sv
module chg_oc_fsm
    import chg_guard_pkg::*;
#(
    parameter int unsigned DET_N = 1000,
    parameter int unsigned REL_N = 40,
    parameter int unsigned CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       test_fast,
    input  logic [1:0] cell_over,
    input  logic [1:0] cell_low,
    input  logic       load_on,
    output qual_out_t  q
);
    localparam logic [CNT_W-1:0] DET_S = CNT_W'(DET_N);
    localparam logic [CNT_W-1:0] DET_F = CNT_W'(fast_count(DET_N));
    localparam logic [CNT_W-1:0] REL_S = CNT_W'(REL_N);
    localparam logic [CNT_W-1:0] REL_F = CNT_W'(fast_count(REL_N));

    qual_st_e         st, st_nx;
    logic             any_over, rel_ok, run, done;
    logic [CNT_W-1:0] limit;

    assign any_over = |cell_over;
    assign rel_ok   = load_on ? !any_over : &cell_low;
    assign run      = (st == ST_ARM) || (st == ST_FREE);
    assign limit    = (st == ST_ARM) ? (test_fast ? DET_F : DET_S)
                                     : (test_fast ? REL_F : REL_S);

    chg_tick_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .limit(limit), .done(done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (any_over) st_nx = ST_ARM;
            ST_ARM:  if (!any_over) st_nx = ST_IDLE;
                     else if (done) st_nx = ST_HELD;
            ST_HELD: if (rel_ok) st_nx = ST_FREE;
            ST_FREE: if (!rel_ok) st_nx = ST_HELD;
                     else if (done) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign q.hold         = (st == ST_HELD) || (st == ST_FREE);
    assign q.release_done = (st == ST_FREE) && rel_ok && done;
endmodule

// File: rtl/chg_ovv_fsm.sv
module chg_ovv_fsm
    import chg_guard_pkg::*;
#(
    parameter int unsigned DET_N = 2,
    parameter int unsigned REL_N = 2,
    parameter int unsigned CNT_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic test_fast,
    input  logic flag,
    input  logic arm,
    input  logic handoff,
    output logic hold
);
    localparam logic [CNT_W-1:0] DET_S = CNT_W'(DET_N);
    localparam logic [CNT_W-1:0] DET_F = CNT_W'(fast_count(DET_N));
    localparam logic [CNT_W-1:0] REL_S = CNT_W'(REL_N);
    localparam logic [CNT_W-1:0] REL_F = CNT_W'(fast_count(REL_N));

    qual_st_e         st, st_nx;
    logic             run, done;
    logic [CNT_W-1:0] limit;

    assign run   = (st == ST_ARM) || (st == ST_FREE);
    assign limit = (st == ST_ARM) ? (test_fast ? DET_F : DET_S)
                                  : (test_fast ? REL_F : REL_S);

    chg_tick_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .limit(limit), .done(done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (handoff && flag) st_nx = ST_HELD;
                     else if (flag && arm) st_nx = ST_ARM;
            ST_ARM:  if (!flag || !arm) st_nx = ST_IDLE;
                     else if (done) st_nx = ST_HELD;
            ST_HELD: if (!flag) st_nx = ST_FREE;
            ST_FREE: if (flag) st_nx = ST_HELD;
                     else if (done) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign hold = (st == ST_HELD) || (st == ST_FREE);
endmodule

// File: rtl/chg_guard_seq.sv
module chg_guard_seq
    import chg_guard_pkg::*;
#(
    parameter int unsigned OC_DET_TICKS  = 1000,
    parameter int unsigned OC_REL_TICKS  = 40,
    parameter int unsigned OVV_DET_TICKS = 2,
    parameter int unsigned OVV_REL_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       test_fast,
    input  logic [1:0] cell_over,
    input  logic [1:0] cell_low,
    input  logic       load_on,
    input  logic       chg_ovv,
    input  logic       dis_on,
    output logic       chg_en,
    output logic       oc_active,
    output logic       ocur_block
);
    localparam int unsigned MAX_TICKS =
        max_of(max_of(OC_DET_TICKS, OC_REL_TICKS), max_of(OVV_DET_TICKS, OVV_REL_TICKS));
    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);

    qual_out_t oc_q;
    logic      ovv_held;
    logic      ovv_arm;
    logic      ovv_handoff;

    chg_oc_fsm #(
        .DET_N(OC_DET_TICKS), .REL_N(OC_REL_TICKS), .CNT_W(CNT_W)
    ) i_oc (
        .clk(clk), .rst(rst), .tick(tick), .test_fast(test_fast),
        .cell_over(cell_over), .cell_low(cell_low), .load_on(load_on),
        .q(oc_q)
    );

    assign ovv_arm     = dis_on && !oc_q.hold;
    assign ovv_handoff = oc_q.release_done && dis_on;

    chg_ovv_fsm #(
        .DET_N(OVV_DET_TICKS), .REL_N(OVV_REL_TICKS), .CNT_W(CNT_W)
    ) i_ovv (
        .clk(clk), .rst(rst), .tick(tick), .test_fast(test_fast),
        .flag(chg_ovv), .arm(ovv_arm), .handoff(ovv_handoff),
        .hold(ovv_held)
    );

    assign chg_en     = !(oc_q.hold || ovv_held);
    assign oc_active  = oc_q.hold;
    assign ocur_block = oc_q.hold;
endmodule

// File: rtl/chg_guard_chk.sv
module chg_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cell_over,
    input logic [1:0] cell_low,
    input logic       load_on,
    input logic       chg_ovv,
    input logic       dis_on,
    input logic       chg_en,
    input logic       oc_active,
    input logic       ocur_block,
    input logic       ovv_held
);
    AST_OC_NEEDS_OVER: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_active) |-> $past(|cell_over)); // R1

    AST_OC_RELEASE_COND: assert property (@(posedge clk) disable iff (rst)
        $fell(oc_active) |-> $past(load_on ? ~|cell_over : &cell_low)); // R2

    AST_BLOCK_GATES_CHG: assert property (@(posedge clk) disable iff (rst)
        ocur_block |-> !chg_en); // R3

    AST_OVV_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(ovv_held) |-> $past(chg_ovv)); // R4

    AST_OVV_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(ovv_held) |-> $past(!chg_ovv)); // R5

    AST_OVV_NEEDS_DIS: assert property (@(posedge clk) disable iff (rst)
        $rose(ovv_held) |-> $past(dis_on)); // R6

    AST_HANDOFF_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        ($fell(oc_active) && $past(chg_ovv && dis_on)) |-> !chg_en); // R7
endmodule

bind chg_guard_seq chg_guard_chk i_chk (
    .clk(clk), .rst(rst), .cell_over(cell_over), .cell_low(cell_low),
    .load_on(load_on), .chg_ovv(chg_ovv), .dis_on(dis_on),
    .chg_en(chg_en), .oc_active(oc_active), .ocur_block(ocur_block),
    .ovv_held(ovv_held)
);

// File: tb/test_chg_guard_seq.sv
module test_chg_guard_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       test_fast = 1'b0;
    logic [1:0] cell_over = 2'b00;
    logic [1:0] cell_low = 2'b00;
    logic       load_on = 1'b0;
    logic       chg_ovv = 1'b0;
    logic       dis_on = 1'b1;
    logic       chg_en, oc_active, ocur_block;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #5 clk = ~clk;

    chg_guard_seq #(
        .OC_DET_TICKS(200), .OC_REL_TICKS(8), .OVV_DET_TICKS(3), .OVV_REL_TICKS(4)
    ) i_chg_guard_seq (
        .clk(clk), .rst(rst), .tick(tick), .test_fast(test_fast),
        .cell_over(cell_over), .cell_low(cell_low), .load_on(load_on),
        .chg_ovv(chg_ovv), .dis_on(dis_on), .chg_en(chg_en),
        .oc_active(oc_active), .ocur_block(ocur_block)
    );

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [2:0] act;
            it  = sb.pop_front();
            act = {chg_en, oc_active, ocur_block};
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: {chg_en,oc_active,ocur_block} actual %b expected %b",
                         it.tag, act, it.exp);
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick_n(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1 tick = 1'b1;
            @(posedge clk); #1 tick = 1'b0;
        end
        settle(1);
    endtask

    task automatic expect_out(input logic [2:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst = 1'b0;
        settle(1);
        expect_out(3'b100, "R9 reset state");

        // R1 abort then full detection
        cell_over = 2'b10; settle(2);
        tick_n(100);
        cell_over = 2'b00; settle(2);
        expect_out(3'b100, "R1 abort keeps enable");
        cell_over = 2'b10; settle(2);
        tick_n(199);
        expect_out(3'b100, "R1 one tick before detect");
        tick_n(1);
        expect_out(3'b011, "R1 R3 overcharge detected");

        // R2 charger-connected release
        cell_over = 2'b00; cell_low = 2'b01; settle(2);
        tick_n(10);
        expect_out(3'b011, "R2 one cell above reset keeps hold");
        cell_low = 2'b11; settle(2);
        tick_n(7);
        expect_out(3'b011, "R3 block during release count");
        tick_n(1);
        expect_out(3'b100, "R2 charger release");
        cell_low = 2'b00;

        // R2 load-connected release with restart
        cell_over = 2'b11; settle(2);
        tick_n(200);
        expect_out(3'b011, "R1 both cells detect");
        load_on = 1'b1; cell_over = 2'b00; settle(2);
        tick_n(4);
        cell_over = 2'b01; settle(2);
        expect_out(3'b011, "R2 condition lost");
        cell_over = 2'b00; settle(2);
        tick_n(7);
        expect_out(3'b011, "R2 release count restarted");
        tick_n(1);
        expect_out(3'b100, "R2 load release");

        // R4 / R5 charger overvoltage
        chg_ovv = 1'b1; settle(2);
        tick_n(2);
        chg_ovv = 1'b0; settle(2);
        expect_out(3'b100, "R4 abort");
        chg_ovv = 1'b1; settle(2);
        tick_n(2);
        expect_out(3'b100, "R4 one tick before detect");
        tick_n(1);
        expect_out(3'b000, "R4 overvoltage detected");
        chg_ovv = 1'b0; settle(2);
        tick_n(3);
        expect_out(3'b000, "R5 one tick before release");
        tick_n(1);
        expect_out(3'b100, "R5 released");

        // R6 discharge switch off
        dis_on = 1'b0; chg_ovv = 1'b1; settle(2);
        tick_n(10);
        expect_out(3'b100, "R6 no detect while discharge off");
        dis_on = 1'b1; settle(2);
        tick_n(2);
        expect_out(3'b100, "R6 count starts after return");
        tick_n(1);
        expect_out(3'b000, "R6 detect after return");
        chg_ovv = 1'b0; settle(2);
        tick_n(4);
        expect_out(3'b100, "R5 release after R6 case");

        // R7 handoff
        load_on = 1'b0; cell_over = 2'b01; settle(2);
        tick_n(200);
        chg_ovv = 1'b1; settle(2);
        tick_n(5);
        expect_out(3'b011, "R7 overvoltage not armed during overcharge");
        load_on = 1'b1; cell_over = 2'b00; settle(2);
        tick_n(8);
        expect_out(3'b000, "R7 handoff keeps enable low");
        chg_ovv = 1'b0; settle(2);
        tick_n(4);
        expect_out(3'b100, "R7 release after handoff");

        // R8 fast test counts: 200->3, others ->1
        test_fast = 1'b1;
        cell_over = 2'b01; settle(2);
        tick_n(2);
        expect_out(3'b100, "R8 fast detect not yet");
        tick_n(1);
        expect_out(3'b011, "R8 fast detect");
        cell_over = 2'b00; settle(2);
        tick_n(1);
        expect_out(3'b100, "R8 fast release");
        chg_ovv = 1'b1; settle(2);
        tick_n(1);
        expect_out(3'b000, "R8 fast overvoltage detect");
        chg_ovv = 1'b0; settle(2);
        tick_n(1);
        expect_out(3'b100, "R8 fast overvoltage release");

        // R9 reset mid-hold
        chg_ovv = 1'b1; settle(2);
        tick_n(1);
        rst = 1'b1; chg_ovv = 1'b0; settle(2);
        rst = 1'b0; settle(1);
        expect_out(3'b100, "R9 reset clears hold");

        settle(2);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule